// File: doc/BRIEF.md
# Six-Stage Pipeline Stall Controller

This block decides, every clock cycle, which stages of a six-stage instruction pipeline move forward and which stand still. The stages, oldest last, are instruction fetch (FI), decode (DI), operand address calculation (CO), operand fetch (FO), execute (EI) and operand write (WO). Each stage is a pipeline register that carries a valid bit and a small hazard descriptor. The descriptor holds two source identifiers with use bits, one destination identifier with a valid bit, and flags for a memory read at FO and a memory write at WO. Registers and memory locations share one identifier space, so one comparison covers both.

Two kinds of hazard cause stalls. The first is contention for the single memory port among instruction fetch, operand read and operand write. The second is a read-after-write dependency, which is resolved by holding FO until the producing instruction has left WO. The design has no forwarding. When a stage stalls, every earlier stage keeps its contents and a bubble enters the stage after it. A flush input discards the three youngest stages after a taken branch.

Instructions enter through a valid/ready pair. The descriptor is normally produced by a predecoder ahead of the fetch slot. The controller reports which requester owns the memory port, which stages are valid, which stages hold and where bubbles go in.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After reset, every stage is empty (`stageVld` = 0), `memSel` is 0 (idle), `stageHold` and `bubbleIns` are 0 and `issueRdy` is 1.
- R2: With no hazards, one instruction is accepted per cycle. An instruction accepted at clock edge t is valid in WO (`stageVld[5]`) after edge t+5, and a run of n instructions leaves WO on n consecutive cycles.
- R3: `memSel` encodes the owner of the memory port: 0 idle, 1 instruction fetch (FI valid), 2 operand read (FO), 3 operand write (WO). The write in WO wins over the read in FO, and the read wins over the fetch. Each fetch, read and write holds the port for exactly one cycle.
- R4: When a valid FI loses the port, FI keeps its instruction, `issueRdy` is 0, `stageHold` is 6'b000001, `bubbleIns` is 5'b00001 (bit k marks a bubble entering stage k+1), and the fetch completes on a later cycle.
- R5: When a read in FO meets a write in WO, FO stalls for one cycle: `stageHold` is 6'b001111, `bubbleIns` is 5'b01000, and the read takes the port on the next cycle.
- R6: An FO source whose use bit is set and that equals the destination of a valid instruction with a valid destination in EI or WO holds FO. A producer in EI costs two stall cycles and a producer in WO costs one. During the stall `stageHold` is 6'b001111 and `bubbleIns` is 5'b01000.
- R7: A matching identifier causes no stall when the consumer's source use bit is 0 or the producer's destination valid bit is 0.
- R8: While `flush` is 1, `issueRdy` is 0. At the next edge FI, DI and CO become empty, the instruction leaving CO does not enter FO, and EI and WO continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard FI, DI and CO (taken branch) |
| issueVld | input | 1 | A new instruction descriptor is offered |
| issueRdy | output | 1 | Descriptor accepted at this edge |
| issueSrcA | input | IdW | First source identifier |
| issueSrcAUse | input | 1 | First source is read |
| issueSrcB | input | IdW | Second source identifier |
| issueSrcBUse | input | 1 | Second source is read |
| issueDst | input | IdW | Destination identifier |
| issueDstVld | input | 1 | Instruction writes its destination |
| issueMemRd | input | 1 | Operand read from memory at FO |
| issueMemWr | input | 1 | Result written to memory at WO |
| memSel | output | 2 | Memory port owner (R3 encoding) |
| stageVld | output | 6 | Valid bit per stage, bit 0 = FI, bit 5 = WO |
| stageHold | output | 6 | Stage keeps its contents this cycle |
| bubbleIns | output | 5 | Bit k: bubble enters stage k+1 because stage k holds |

## Verification
The hardest situation to reach from the ports is a read in FO colliding with a write in WO. It needs a writing instruction exactly two slots ahead of a reading one, and the fetch slot must also be occupied for the second port loss to become visible. The stimulus sweeps that pair across every position of a twelve-instruction stream and predicts the extra cycles arithmetically from the position. The dependency tests sweep the distance between producer and consumer, the source slot, and the use and destination-valid bits. Each prediction is compared against the cycle of the last retirement.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  localparam int NSTG = 6;
  localparam int NSRC = 2;
  localparam int NPROD = 2;

  localparam int S_FI = 0;
  localparam int S_DI = 1;
  localparam int S_CO = 2;
  localparam int S_FO = 3;
  localparam int S_EI = 4;
  localparam int S_WO = 5;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_FETCH = 2'd1,
    MS_OPRD  = 2'd2,
    MS_OPWR  = 2'd3
  } memSel_e;

  typedef struct packed {
    logic [NSTG-1:0] hold;
    logic [NSTG-1:0] load;
    logic [NSTG-1:0] clear;
  } stageStb_t;

endpackage

// File: rtl/hzc_datapath.sv
module hzc_datapath
  import hzc_pkg::*;
#(
  parameter int IdW = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  stageStb_t                       stb,
  input  logic                            inVld,
  input  logic [NSRC-1:0][IdW-1:0]        inSrc,
  input  logic [NSRC-1:0]                 inSrcUse,
  input  logic [IdW-1:0]                  inDst,
  input  logic                            inDstVld,
  input  logic                            inMemRd,
  input  logic                            inMemWr,
  output logic [NSTG-1:0]                 vldQ,
  output logic [NSRC-1:0][IdW-1:0]        foSrc,
  output logic [NSRC-1:0]                 foSrcUse,
  output logic                            foMemRd,
  output logic                            woMemWr,
  output logic [NPROD-1:0][IdW-1:0]       prodDst,
  output logic [NPROD-1:0]                prodLive
);

  typedef struct packed {
    logic                     vld;
    logic [NSRC-1:0][IdW-1:0] src;
    logic [NSRC-1:0]          srcUse;
    logic [IdW-1:0]           dst;
    logic                     dstVld;
    logic                     memRd;
    logic                     memWr;
  } entry_t;

  entry_t pipeQ [NSTG];
  entry_t feed  [NSTG];

  for (genvar i = 0; i < NSTG; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_comb begin
        feed[i].vld    = inVld;
        feed[i].src    = inSrc;
        feed[i].srcUse = inSrcUse;
        feed[i].dst    = inDst;
        feed[i].dstVld = inDstVld;
        feed[i].memRd  = inMemRd;
        feed[i].memWr  = inMemWr;
      end
    end else begin : g_link
      assign feed[i] = pipeQ[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipeQ[i] <= '0;
      end else if (stb.clear[i]) begin
        pipeQ[i].vld <= 1'b0;
      end else if (stb.load[i]) begin
        pipeQ[i] <= feed[i];
      end
    end

    assign vldQ[i] = pipeQ[i].vld;

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      (stb.hold[i] && !stb.clear[i]) |=> $stable(pipeQ[i])); // R4
  end

  assign foSrc    = pipeQ[S_FO].src;
  assign foSrcUse = pipeQ[S_FO].srcUse;
  assign foMemRd  = pipeQ[S_FO].memRd;
  assign woMemWr  = pipeQ[S_WO].memWr;

  for (genvar c = 0; c < NPROD; c++) begin : g_prod
    assign prodDst[c]  = pipeQ[S_EI+c].dst;
    assign prodLive[c] = pipeQ[S_EI+c].vld && pipeQ[S_EI+c].dstVld;
  end

  AST_EI_FLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pipeQ[S_EI].vld |=> pipeQ[S_WO].vld); // R2

endmodule

// File: rtl/hzc_control.sv
module hzc_control
  import hzc_pkg::*;
#(
  parameter int IdW = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic [NSTG-1:0]            vldQ,
  input  logic [NSRC-1:0][IdW-1:0]   foSrc,
  input  logic [NSRC-1:0]            foSrcUse,
  input  logic                       foMemRd,
  input  logic                       woMemWr,
  input  logic [NPROD-1:0][IdW-1:0]  prodDst,
  input  logic [NPROD-1:0]           prodLive,
  output stageStb_t                  stb,
  output memSel_e                    memSel,
  output logic                       issueRdy,
  output logic [NSTG-2:0]            bubble
);

  logic [NSRC-1:0][NPROD-1:0] hit;
  logic [NSTG-1:0] hold;
  logic [NSTG-1:0] clr;
  logic raw, woWr, foRdReq, foStall, foGo, fiBlk;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar c = 0; c < NPROD; c++) begin : g_cmp
      assign hit[s][c] = foSrcUse[s] && prodLive[c] && (foSrc[s] == prodDst[c]);
    end
  end

  assign raw     = vldQ[S_FO] && (|hit);
  assign woWr    = vldQ[S_WO] && woMemWr;
  assign foRdReq = vldQ[S_FO] && foMemRd;
  assign foStall = raw || (foRdReq && woWr);
  assign foGo    = foRdReq && !foStall;
  assign fiBlk   = vldQ[S_FI] && (woWr || foGo);

  for (genvar i = 0; i < NSTG; i++) begin : g_hold
    if (i == S_FI) begin : g_fi
      assign hold[i] = foStall || fiBlk;
    end else if (i <= S_FO) begin : g_front
      assign hold[i] = foStall;
    end else begin : g_back
      assign hold[i] = 1'b0;
    end
  end

  for (genvar k = 0; k < NSTG-1; k++) begin : g_bub
    assign bubble[k] = hold[k] && !hold[k+1];
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_clr
    if (i == 0) begin : g_first
      assign clr[i] = flush;
    end else begin : g_rest
      localparam bit Front   = (i <= S_CO);
      localparam bit UpFront = ((i - 1) <= S_CO);
      assign clr[i] = (Front && flush) ||
                      (!hold[i] && (hold[i-1] || (UpFront && flush)));
    end
  end

  assign stb.hold  = hold;
  assign stb.clear = clr;
  assign stb.load  = ~hold & ~clr;

  always_comb begin
    if (woWr)            memSel = MS_OPWR;
    else if (foGo)       memSel = MS_OPRD;
    else if (vldQ[S_FI]) memSel = MS_FETCH;
    else                 memSel = MS_IDLE;
  end

  assign issueRdy = !flush && !hold[S_FI];

  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (vldQ[S_WO] && woMemWr) |-> (memSel == MS_OPWR)); // R3
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (vldQ[S_FO] && foMemRd && vldQ[S_WO] && woMemWr) |-> stb.hold[S_FO]); // R5
  AST_RAW_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (vldQ[S_FO] && (|hit)) |-> (memSel != MS_OPRD && bubble[S_FO])); // R6
  AST_FLUSH_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !issueRdy); // R8

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int IdW = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            flush,
  input  logic            issueVld,
  output logic            issueRdy,
  input  logic [IdW-1:0]  issueSrcA,
  input  logic            issueSrcAUse,
  input  logic [IdW-1:0]  issueSrcB,
  input  logic            issueSrcBUse,
  input  logic [IdW-1:0]  issueDst,
  input  logic            issueDstVld,
  input  logic            issueMemRd,
  input  logic            issueMemWr,
  output logic [1:0]      memSel,
  output logic [NSTG-1:0] stageVld,
  output logic [NSTG-1:0] stageHold,
  output logic [NSTG-2:0] bubbleIns
);

  stageStb_t                  stb;
  memSel_e                    selE;
  logic [NSRC-1:0][IdW-1:0]   foSrc;
  logic [NSRC-1:0]            foSrcUse;
  logic                       foMemRd, woMemWr;
  logic [NPROD-1:0][IdW-1:0]  prodDst;
  logic [NPROD-1:0]           prodLive;

  hzc_datapath #(.IdW(IdW)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inVld    (issueVld),
    .inSrc    ({issueSrcB, issueSrcA}),
    .inSrcUse ({issueSrcBUse, issueSrcAUse}),
    .inDst    (issueDst),
    .inDstVld (issueDstVld),
    .inMemRd  (issueMemRd),
    .inMemWr  (issueMemWr),
    .vldQ     (stageVld),
    .foSrc    (foSrc),
    .foSrcUse (foSrcUse),
    .foMemRd  (foMemRd),
    .woMemWr  (woMemWr),
    .prodDst  (prodDst),
    .prodLive (prodLive)
  );

  hzc_control #(.IdW(IdW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .vldQ     (stageVld),
    .foSrc    (foSrc),
    .foSrcUse (foSrcUse),
    .foMemRd  (foMemRd),
    .woMemWr  (woMemWr),
    .prodDst  (prodDst),
    .prodLive (prodLive),
    .stb      (stb),
    .memSel   (selE),
    .issueRdy (issueRdy),
    .bubble   (bubbleIns)
  );

  assign memSel    = selE;
  assign stageHold = stb.hold;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (stageVld[S_CO:0] == '0)); // R8

endmodule

// File: tb/tb_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctrl;

  localparam int IDW   = 3;
  localparam int CLK_P = 8;

  logic clk = 1'b0;
  logic rstN, flush, issueVld, issueRdy;
  logic [IDW-1:0] issueSrcA, issueSrcB, issueDst;
  logic issueSrcAUse, issueSrcBUse, issueDstVld, issueMemRd, issueMemWr;
  logic [1:0] memSel;
  logic [5:0] stageVld, stageHold;
  logic [4:0] bubbleIns;

  pipe_hazard_ctrl #(.IdW(IDW)) dut (
    .clk(clk), .rstN(rstN), .flush(flush), .issueVld(issueVld), .issueRdy(issueRdy),
    .issueSrcA(issueSrcA), .issueSrcAUse(issueSrcAUse), .issueSrcB(issueSrcB),
    .issueSrcBUse(issueSrcBUse), .issueDst(issueDst), .issueDstVld(issueDstVld),
    .issueMemRd(issueMemRd), .issueMemWr(issueMemWr), .memSel(memSel),
    .stageVld(stageVld), .stageHold(stageHold), .bubbleIns(bubbleIns)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [IDW-1:0] a; logic au;
    logic [IDW-1:0] b; logic bu;
    logic [IDW-1:0] d; logic dv;
    logic rd; logic wr;
  } ins_t;

  ins_t prog [16];
  int nChk = 0, nFail = 0;
  bit done = 0;
  int cyc, firstRet;
  int selCnt [4];
  logic [1:0] selTr  [64];
  logic [5:0] holdTr [64];
  logic [4:0] bubTr  [64];

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadFill(input int n);
    for (int j = 0; j < 16; j++)
      prog[j] = '{a:3'd0, au:1'b0, b:3'd0, bu:1'b0, d:3'd1, dv:1'b1, rd:1'b0, wr:1'b0};
  endtask

  task automatic drive(input ins_t x);
    issueSrcA = x.a; issueSrcAUse = x.au; issueSrcB = x.b; issueSrcBUse = x.bu;
    issueDst = x.d; issueDstVld = x.dv; issueMemRd = x.rd; issueMemWr = x.wr;
  endtask

  task automatic runProg(input int n, output int last);
    int idx, ret;
    bit acc;
    idx = 0; ret = 0; last = -1; firstRet = -1; cyc = 0;
    for (int k = 0; k < 4; k++) selCnt[k] = 0;
    for (int k = 0; k < 64; k++) begin selTr[k] = 0; holdTr[k] = 0; bubTr[k] = 0; end
    while (ret < n && cyc < 150) begin
      if (idx < n) begin issueVld = 1'b1; drive(prog[idx]); end
      else issueVld = 1'b0;
      #1;
      acc = issueVld && issueRdy;
      @(posedge clk);
      cyc++;
      if (acc) idx++;
      @(negedge clk);
      if (stageVld[5]) begin
        ret++; last = cyc;
        if (firstRet < 0) firstRet = cyc;
      end
      selCnt[memSel]++;
      if (cyc < 64) begin selTr[cyc] = memSel; holdTr[cyc] = stageHold; bubTr[cyc] = bubbleIns; end
    end
    issueVld = 1'b0;
  endtask

  initial begin
    int last, exp, stall, ret;
    rstN = 1'b0; flush = 1'b0; issueVld = 1'b0;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 stageVld", stageVld, 0);
    chk("R1 memSel", memSel, 0);
    chk("R1 stageHold", stageHold, 0);
    chk("R1 bubbleIns", bubbleIns, 0);
    chk("R1 issueRdy", issueRdy, 1);
    @(negedge clk);

    // R2: hazard-free stream
    loadFill(12);
    runProg(12, last);
    chk("R2 last retire", last, 17);
    chk("R2 first retire", firstRet, 6);
    chk("R3 fetch count", selCnt[1], 12);

    // R4: single operand read at every position
    for (int p = 0; p < 12; p++) begin
      loadFill(12); prog[p].rd = 1'b1;
      runProg(12, last);
      exp = 17 + ((p + 3 <= 11) ? 1 : 0);
      chk("R4 read delay", last, exp);
      chk("R3 read count", selCnt[2], 1);
      chk("R3 read slot", selTr[p+4], 2);
      if (p + 3 <= 11) begin
        chk("R4 hold FI", holdTr[p+4], 6'b000001);
        chk("R4 bubble DI", bubTr[p+4], 5'b00001);
      end
    end

    // R3/R4: single operand write at every position
    for (int p = 0; p < 12; p++) begin
      loadFill(12); prog[p].wr = 1'b1;
      runProg(12, last);
      exp = 17 + ((p + 5 <= 11) ? 1 : 0);
      chk("R4 write delay", last, exp);
      chk("R3 write slot", selTr[p+6], 3);
      chk("R3 write count", selCnt[3], 1);
      if (p + 5 <= 11) chk("R4 hold FI on write", holdTr[p+6], 6'b000001);
    end

    // R5: write two slots ahead of a read collides at FO/WO
    for (int p = 2; p < 12; p++) begin
      loadFill(12); prog[p].rd = 1'b1; prog[p-2].wr = 1'b1;
      runProg(12, last);
      exp = 17 + ((p + 3 <= 11) ? 2 : 1);
      chk("R5 collision delay", last, exp);
      chk("R3 write first", selTr[p+4], 3);
      chk("R3 read next", selTr[p+5], 2);
      chk("R5 hold", holdTr[p+4], 6'b001111);
      chk("R5 bubble EI", bubTr[p+4], 5'b01000);
    end

    // R6/R7: producer-consumer distance, slot and mask sweep
    for (int d = 1; d <= 4; d++)
      for (int slot = 0; slot < 2; slot++)
        for (int mode = 0; mode < 3; mode++) begin
          loadFill(8);
          prog[0].d = 3'd7; prog[0].dv = (mode != 2);
          if (slot == 0) begin prog[d].a = 3'd7; prog[d].au = (mode != 1); end
          else begin prog[d].b = 3'd7; prog[d].bu = (mode != 1); end
          runProg(8, last);
          stall = (mode == 0) ? ((d == 1) ? 2 : (d == 2) ? 1 : 0) : 0;
          if (mode == 0) chk("R6 dependency delay", last, 13 + stall);
          else chk("R7 no false stall", last, 13);
          if (stall > 0) begin
            chk("R6 hold", holdTr[d+4], 6'b001111);
            chk("R6 bubble EI", bubTr[d+4], 5'b01000);
          end
        end

    // R8: flush with five instructions in flight
    loadFill(8);
    for (int k = 0; k < 5; k++) begin
      issueVld = 1'b1; drive(prog[k]);
      @(posedge clk); @(negedge clk);
    end
    flush = 1'b1; issueVld = 1'b1; drive(prog[5]);
    #1;
    chk("R8 issueRdy during flush", issueRdy, 0);
    @(posedge clk); @(negedge clk);
    flush = 1'b0; issueVld = 1'b0;
    chk("R8 stages after flush", stageVld, 6'b110000);
    ret = stageVld[5];
    repeat (6) begin
      @(posedge clk); @(negedge clk);
      ret += stageVld[5];
    end
    chk("R8 survivors", ret, 2);
    chk("R8 drained", stageVld, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule